// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Decoder with Parallel Test Compression

This block is the device-side control of a DRAM model whose address pins carry the row and the column at different times. A fast clock samples the active-low row strobe, column strobe, write enable and output enable. The block works out from the order of their edges what kind of cycle the host is running: read, early write, row-only refresh, column-before-row refresh, hidden refresh, or entry to the parallel test mode. It drives the output-enable of the four-bit data port and updates a small register-file array. It also keeps a ten-bit internal refresh row counter that advances on each internally addressed refresh.

In parallel test mode one data bit is written into eight array sections at once. A read compares the eight sections and returns a single pass/fail result on all four data pins. The model then behaves as half its size, because the lowest column address bit is ignored. A host uses the block as it would a plain asynchronous DRAM: it lowers the row strobe with the row on the address pins, then lowers the column strobe with the column on them. With the column strobe held low it may keep the read data on the pins while the row strobe cycles for refresh.

The state machine has six states. `ST_IDLE` means the row strobe is high. `ST_ROW` means a row is open with the column strobe high. `ST_READ` and `ST_WRITE` are column accesses. `ST_HOLD` means the row strobe is high while the column strobe stays low. `ST_REFRESH` is a refresh with an internal address.

The transitions are:
- IDLE→ROW: row strobe falls while the column strobe was high.
- IDLE→REFRESH: row strobe falls while the column strobe was already low.
- ROW→READ or ROW→WRITE: column strobe low, with write enable high or low.
- ROW→IDLE: row strobe rises.
- READ/WRITE→ROW: column strobe rises.
- READ/WRITE→HOLD: row strobe rises with the column strobe still low.
- READ/WRITE→IDLE: both strobes rise.
- HOLD→REFRESH: row strobe falls.
- HOLD→IDLE: column strobe rises.
- REFRESH→HOLD or REFRESH→IDLE: row strobe rises, with the column strobe low or high.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset `dq_oe` is 0, `test_mode` is 0, `rfsh_row` is 0 and `cycle_kind` is 0 (none).
- R2: A read latches the row from `addr` in the sample where `ras_n` is first low and the column from `addr` in the sample where `cas_n` is low with `we_n` high. After that clock edge `dq_out` holds word {row,col}, `cycle_kind` is 1 and `dq_oe` is 1 while `oe_n` is low.
- R3: With `we_n` low in the sample where `cas_n` goes low (early write), `dq_in` is stored to word {row,col` and `cycle_kind` becomes 2. `dq_oe` stays 0 for the whole cycle whatever `oe_n` does.
- R4: `dq_oe` is 0 in the same sample in which `oe_n` is high. It is 0 after the clock edge at which `cas_n` is sampled high.
- R5: Page mode: several column-strobe pulses within one row-strobe low period all use the row latched at the row strobe's fall.
- R6: A row-strobe low period with no column access is a row-only refresh. `cycle_kind` becomes 3 at the rise, and neither the array nor `rfsh_row` changes.
- R7: If `cas_n` was low in the sample before `ras_n` falls and `we_n` is high, the cycle is a column-before-row refresh. `cycle_kind` becomes 4, `rfsh_row` increments modulo 1024, `addr` is ignored and `dq_oe` stays 0.
- R8: Hidden refresh: after a read, `cas_n` held low while `ras_n` rises and falls again gives `cycle_kind` 5 and increments `rfsh_row`. `dq_oe` and `dq_out` keep the read data.
- R9: The column-before-row ordering with `we_n` low sets `test_mode`, gives `cycle_kind` 6 and leaves `rfsh_row` unchanged.
- R10: A test-mode write stores `{4{dq_in[0]}}` into both words {row,col with bit 0 = 0} and {row,col with bit 0 = 1}, ignoring column bit 0.
- R11: A test-mode read gives `dq_out` = 4'b1111 if all eight bits of that word pair are equal, else 4'b0000.
- R12: A row-only refresh, a column-before-row refresh or a hidden refresh clears `test_mode`.
- R13: Successive column-before-row refreshes with `cas_n` held low each increment `rfsh_row`, and the counter wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (3) | Multiplexed row/column address |
| dq_in | input | DQ_W (4) | Write data |
| dq_out | output | DQ_W (4) | Read data or test compare result |
| dq_oe | output | 1 | Data port driven (low impedance) |
| test_mode | output | 1 | Parallel test mode active |
| cycle_kind | output | 3 | Last classified cycle: 0 none, 1 read, 2 early write, 3 row-only, 4 column-before-row, 5 hidden, 6 test entry |
| rfsh_row | output | RFSH_W (10) | Internal refresh row counter |

## Verification
The bench drives strobes on the falling clock edge and samples one time unit after the next rising edge. Read data, `dq_oe` going high, `cycle_kind` and the array write are all due at the first rising edge that sees the new strobe level, so each check sits right after that edge. The exceptions are the row-only classification, which is due at the edge that sees `ras_n` high, and the output-enable release on `oe_n`, which is combinational and checked in the same sample. The refresh count and test-mode flag are read after the edge that sees the row strobe's fall. Results are compared with a bench model of the array, the test compression and the counter.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ROW     = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_HOLD    = 3'd4,
        ST_REFRESH = 3'd5
    } dcc_state_e;

    typedef enum logic [2:0] {
        CK_NONE       = 3'd0,
        CK_READ       = 3'd1,
        CK_WRITE      = 3'd2,
        CK_RAS_ONLY   = 3'd3,
        CK_CBR        = 3'd4,
        CK_HIDDEN     = 3'd5,
        CK_TEST_ENTRY = 3'd6
    } dcc_kind_e;

endpackage

// File: rtl/dcc_strobe_sampler.sv
module dcc_strobe_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output logic ras_fall,
    output logic cas_prev_low
);
    logic ras_q;
    logic cas_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign ras_fall     = ras_q & ~ras_n;
    assign cas_prev_low = ~cas_q;

endmodule

// File: rtl/dcc_refresh_ctr.sv
module dcc_refresh_ctr #(
    parameter int RFSH_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [RFSH_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_refresh_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count == $past(count) + 1'b1));

    assert_refresh_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/dcc_store.sv
module dcc_store #(
    parameter int DQ_W     = 4,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         test_mode,
    input  logic [ROW_BITS+COL_BITS-1:0] idx,
    input  logic [DQ_W-1:0]              wdata,
    output logic [DQ_W-1:0]              rd_word,
    output logic [DQ_W-1:0]              rd_cmp
);
    localparam int IDX_W  = ROW_BITS + COL_BITS;
    localparam int WORDS  = 1 << IDX_W;
    localparam int SECT_W = 2 * DQ_W;

    logic [DQ_W-1:0]   mem [WORDS];
    logic [IDX_W-2:0]  pair_base;
    logic [SECT_W-1:0] sections;

    assign pair_base = idx[IDX_W-1:1];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic hit;
        assign hit = test_mode ? (MY_IDX[IDX_W-1:1] == pair_base) : (MY_IDX == idx);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem[g] <= '0;
            else if (wr_en && hit) mem[g] <= test_mode ? {DQ_W{wdata[0]}} : wdata;
        end
    end

    assign rd_word  = mem[idx];
    assign sections = {mem[{pair_base, 1'b1}], mem[{pair_base, 1'b0}]};
    assign rd_cmp   = ((&sections) || !(|sections)) ? {DQ_W{1'b1}} : {DQ_W{1'b0}};

    assert_test_pair_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && test_mode) |=> ($past(idx[IDX_W-1:1]) != idx[IDX_W-1:1]) || (rd_cmp == {DQ_W{1'b1}}));

endmodule

// File: rtl/dcc_cycle_fsm.sv
module dcc_cycle_fsm
    import dcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       ras_fall,
    input  logic       cas_prev_low,
    output logic       ev_row,
    output logic       ev_col,
    output logic       ev_wr,
    output logic       rfsh_inc,
    output logic       test_mode,
    output logic [2:0] kind,
    output logic       dq_oe
);
    dcc_state_e state, nxt;
    dcc_kind_e  kind_q;
    logic       col_seen;
    logic       hold;
    logic       ev_cbr, ev_hidden, ev_tent, ev_ronly;

    always_comb begin
        nxt       = state;
        ev_row    = 1'b0;
        ev_col    = 1'b0;
        ev_wr     = 1'b0;
        ev_cbr    = 1'b0;
        ev_hidden = 1'b0;
        ev_tent   = 1'b0;
        ev_ronly  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (cas_prev_low) begin
                        nxt = ST_REFRESH;
                        if (!we_n) ev_tent = 1'b1;
                        else       ev_cbr  = 1'b1;
                    end else begin
                        nxt    = ST_ROW;
                        ev_row = 1'b1;
                    end
                end
            end
            ST_ROW: begin
                if (ras_n) begin
                    nxt      = ST_IDLE;
                    ev_ronly = !col_seen;
                end else if (!cas_n) begin
                    ev_col = 1'b1;
                    ev_wr  = !we_n;
                    nxt    = we_n ? ST_READ : ST_WRITE;
                end
            end
            ST_READ, ST_WRITE: begin
                if (cas_n)      nxt = ras_n ? ST_IDLE : ST_ROW;
                else if (ras_n) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cas_n) begin
                    nxt = ST_IDLE;
                end else if (!ras_n) begin
                    nxt = ST_REFRESH;
                    if (hold)       ev_hidden = 1'b1;
                    else if (!we_n) ev_tent   = 1'b1;
                    else            ev_cbr    = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (ras_n) nxt = cas_n ? ST_IDLE : ST_HOLD;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= CK_NONE;
            test_mode <= 1'b0;
            col_seen  <= 1'b0;
            hold      <= 1'b0;
        end else begin
            if (ev_row) col_seen <= 1'b0;
            if (ev_col) begin
                col_seen <= 1'b1;
                kind_q   <= we_n ? CK_READ : CK_WRITE;
            end
            if (cas_n)       hold <= 1'b0;
            else if (ev_col) hold <= we_n;
            if (ev_ronly) begin
                kind_q    <= CK_RAS_ONLY;
                test_mode <= 1'b0;
            end
            if (ev_cbr) begin
                kind_q    <= CK_CBR;
                test_mode <= 1'b0;
            end
            if (ev_hidden) begin
                kind_q    <= CK_HIDDEN;
                test_mode <= 1'b0;
            end
            if (ev_tent) begin
                kind_q    <= CK_TEST_ENTRY;
                test_mode <= 1'b1;
            end
        end
    end

    always_comb begin
        rfsh_inc = ev_cbr | ev_hidden;
        kind     = kind_q;
        dq_oe    = !oe_n && hold &&
                   ((state == ST_READ) || (state == ST_HOLD) || (state == ST_REFRESH));
    end

    assert_test_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tent |=> test_mode);

    assert_test_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ronly || ev_cbr || ev_hidden) |=> !test_mode);

    assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_row, ev_col, ev_cbr, ev_hidden, ev_tent, ev_ronly}));

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
    parameter int DQ_W     = 4,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter int AW       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
    parameter int RFSH_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              test_mode,
    output logic [2:0]        cycle_kind,
    output logic [RFSH_W-1:0] rfsh_row
);
    localparam int IDX_W = ROW_BITS + COL_BITS;

    logic                ras_fall, cas_prev_low;
    logic                ev_row, ev_col, ev_wr, rfsh_inc;
    logic [ROW_BITS-1:0] row_q;
    logic [IDX_W-1:0]    idx;
    logic [DQ_W-1:0]     rd_word, rd_cmp;
    logic [DQ_W-1:0]     dout_q;

    dcc_strobe_sampler u_sampler (
        .clk          (clk),
        .rst_n        (rst_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .ras_fall     (ras_fall),
        .cas_prev_low (cas_prev_low)
    );

    dcc_cycle_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .oe_n         (oe_n),
        .ras_fall     (ras_fall),
        .cas_prev_low (cas_prev_low),
        .ev_row       (ev_row),
        .ev_col       (ev_col),
        .ev_wr        (ev_wr),
        .rfsh_inc     (rfsh_inc),
        .test_mode    (test_mode),
        .kind         (cycle_kind),
        .dq_oe        (dq_oe)
    );

    dcc_refresh_ctr #(.RFSH_W(RFSH_W)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rfsh_inc),
        .count (rfsh_row)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      row_q <= '0;
        else if (ev_row) row_q <= addr[ROW_BITS-1:0];
    end

    assign idx = {row_q, addr[COL_BITS-1:0]};

    dcc_store #(.DQ_W(DQ_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ev_wr),
        .test_mode (test_mode),
        .idx       (idx),
        .wdata     (dq_in),
        .rd_word   (rd_word),
        .rd_cmp    (rd_cmp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dout_q <= '0;
        else if (ev_col && we_n)   dout_q <= test_mode ? rd_cmp : rd_word;
    end

    assign dq_out = dout_q;

    assert_drive_needs_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> cas_prev_low);

    assert_driven_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    assert_no_drive_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == 3'd2) |-> !dq_oe);

    assert_no_drive_cbr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cycle_kind == 3'd4) || (cycle_kind == 3'd6)) |-> !dq_oe);

endmodule

// File: tb/dram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module dram_cycle_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [2:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic       dq_oe, test_mode;
    logic [2:0] cycle_kind;
    logic [9:0] rfsh_row;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0] mdl [64];
    bit         mdl_tm = 1'b0;
    logic [9:0] exp_rf = '0;

    always #5 clk = ~clk;

    dram_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .test_mode(test_mode), .cycle_kind(cycle_kind), .rfsh_row(rfsh_row)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input int a, input logic [3:0] d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a[2:0]; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] exp_test(input int row, input int col);
        logic [7:0] pair;
        pair = {mdl[row*8 + (col | 1)], mdl[row*8 + (col & 6)]};
        return (pair == 8'hFF || pair == 8'h00) ? 4'hF : 4'h0;
    endfunction

    function automatic logic [3:0] exp_read(input int row, input int col);
        return mdl_tm ? exp_test(row, col) : mdl[row*8 + col];
    endfunction

    task automatic do_write(input int row, input int col, input logic [3:0] d);
        drv(0, 1, 1, 1, row, 4'h0);
        drv(0, 1, 0, 0, row, 4'h0);
        drv(0, 0, 0, 0, col, d);
        chk(dq_oe == 1'b0, "R3", "early write drives port", dq_oe, 0);
        chk(cycle_kind == 3'd2, "R3", "write kind", cycle_kind, 2);
        drv(0, 0, 0, 0, col, d);
        chk(dq_oe == 1'b0, "R3", "early write with oe low", dq_oe, 0);
        drv(0, 1, 1, 1, col, 4'h0);
        drv(1, 1, 1, 1, 0, 4'h0);
        if (mdl_tm) begin
            mdl[row*8 + (col & 6)] = {4{d[0]}};
            mdl[row*8 + (col | 1)] = {4{d[0]}};
        end else begin
            mdl[row*8 + col] = d;
        end
    endtask

    task automatic do_read(input int row, input int col, input string req);
        logic [3:0] e;
        e = exp_read(row, col);
        drv(0, 1, 1, 0, row, 4'h0);
        drv(0, 0, 1, 0, col, 4'h0);
        chk(dq_oe == 1'b1, req, "read drive", dq_oe, 1);
        chk(dq_out == e, req, "read data", dq_out, e);
        chk(cycle_kind == 3'd1, req, "read kind", cycle_kind, 1);
        drv(0, 1, 1, 0, col, 4'h0);
        chk(dq_oe == 1'b0, "R4", "cas rise releases port", dq_oe, 0);
        drv(1, 1, 1, 1, 0, 4'h0);
    endtask

    task automatic do_cbr(input logic w);
        drv(1, 0, w, 0, 5, 4'h0);
        drv(0, 0, w, 0, 5, 4'h0);
        drv(1, 0, 1, 1, 0, 4'h0);
        drv(1, 1, 1, 1, 0, 4'h0);
    endtask

    task automatic do_ras_only(input int row);
        drv(0, 1, 1, 0, row, 4'h0);
        drv(0, 1, 1, 0, row, 4'h0);
        drv(1, 1, 1, 1, row, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 64; i++) mdl[i] = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(dq_oe == 1'b0, "R1", "reset dq_oe", dq_oe, 0);
        chk(test_mode == 1'b0, "R1", "reset test_mode", test_mode, 0);
        chk(rfsh_row == 10'd0, "R1", "reset rfsh_row", rfsh_row, 0);
        chk(cycle_kind == 3'd0, "R1", "reset kind", cycle_kind, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 directed
        do_write(2, 5, 4'hA);
        do_write(7, 0, 4'h3);
        do_read(2, 5, "R2");
        do_read(7, 0, "R2");

        // R4 output enable gating
        drv(0, 1, 1, 1, 2, 4'h0);
        drv(0, 0, 1, 1, 5, 4'h0);
        chk(dq_oe == 1'b0, "R4", "oe high keeps port off", dq_oe, 0);
        drv(0, 0, 1, 0, 5, 4'h0);
        chk(dq_oe == 1'b1, "R4", "oe low drives", dq_oe, 1);
        chk(dq_out == 4'hA, "R2", "data under oe", dq_out, 10);
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        chk(dq_oe == 1'b0, "R4", "oe rise same sample", dq_oe, 0);
        drv(0, 1, 1, 1, 5, 4'h0);
        drv(1, 1, 1, 1, 0, 4'h0);

        // R5 page mode
        do_write(4, 1, 4'h1);
        do_write(4, 6, 4'h6);
        do_write(1, 1, 4'h9);
        drv(0, 1, 1, 0, 4, 4'h0);
        for (int k = 0; k < 3; k++) begin
            int c;
            c = (k == 0) ? 1 : (k == 1) ? 6 : 1;
            drv(0, 0, 1, 0, c, 4'h0);
            chk(dq_out == mdl[32 + c], "R5", "page read", dq_out, mdl[32 + c]);
            drv(0, 1, 1, 0, c, 4'h0);
        end
        drv(1, 1, 1, 1, 0, 4'h0);

        // R6 row-only refresh
        do_ras_only(2);
        chk(cycle_kind == 3'd3, "R6", "row-only kind", cycle_kind, 3);
        chk(rfsh_row == exp_rf, "R6", "counter unchanged", rfsh_row, exp_rf);
        do_read(2, 5, "R6");

        // R7 column-before-row refresh
        drv(1, 0, 1, 0, 5, 4'h0);
        drv(0, 0, 1, 0, 5, 4'h0);
        exp_rf = exp_rf + 1'b1;
        chk(cycle_kind == 3'd4, "R7", "cbr kind", cycle_kind, 4);
        chk(rfsh_row == exp_rf, "R7", "cbr count", rfsh_row, exp_rf);
        chk(dq_oe == 1'b0, "R7", "cbr port off", dq_oe, 0);
        // R13 successive with cas low, including wrap
        for (int n = 0; n < 1024; n++) begin
            drv(1, 0, 1, 0, 0, 4'h0);
            drv(0, 0, 1, 0, 0, 4'h0);
            exp_rf = exp_rf + 1'b1;
        end
        chk(rfsh_row == exp_rf, "R13", "successive cbr wrap", rfsh_row, exp_rf);
        chk(dq_oe == 1'b0, "R7", "cbr port off", dq_oe, 0);
        drv(1, 0, 1, 1, 0, 4'h0);
        drv(1, 1, 1, 1, 0, 4'h0);
        do_read(7, 0, "R7");

        // R8 hidden refresh
        drv(0, 1, 1, 0, 2, 4'h0);
        drv(0, 0, 1, 0, 5, 4'h0);
        drv(1, 0, 1, 0, 3, 4'h0);
        chk(dq_oe == 1'b1 && dq_out == 4'hA, "R8", "hold after read", dq_out, 10);
        drv(0, 0, 1, 0, 3, 4'h0);
        exp_rf = exp_rf + 1'b1;
        chk(cycle_kind == 3'd5, "R8", "hidden kind", cycle_kind, 5);
        chk(rfsh_row == exp_rf, "R8", "hidden count", rfsh_row, exp_rf);
        chk(dq_oe == 1'b1 && dq_out == 4'hA, "R8", "hidden keeps data", dq_out, 10);
        drv(1, 0, 1, 0, 3, 4'h0);
        drv(1, 1, 1, 0, 3, 4'h0);
        chk(dq_oe == 1'b0, "R4", "cas rise after hidden", dq_oe, 0);

        // R9 test entry
        drv(1, 0, 0, 1, 0, 4'h0);
        drv(0, 0, 0, 1, 0, 4'h0);
        chk(test_mode == 1'b1, "R9", "test mode set", test_mode, 1);
        chk(cycle_kind == 3'd6, "R9", "test entry kind", cycle_kind, 6);
        chk(rfsh_row == exp_rf, "R9", "count unchanged", rfsh_row, exp_rf);
        drv(1, 0, 1, 1, 0, 4'h0);
        drv(1, 1, 1, 1, 0, 4'h0);
        mdl_tm = 1'b1;

        // R10 R11 test write and compare
        do_write(3, 4, 4'b0001);
        do_read(3, 5, "R11");
        do_write(6, 3, 4'b1110);
        do_read(6, 2, "R11");
        do_ras_only(0);
        chk(test_mode == 1'b0, "R12", "row-only exits test", test_mode, 1'b0);
        mdl_tm = 1'b0;
        do_read(3, 4, "R10");
        do_read(3, 5, "R10");
        do_read(6, 2, "R10");
        do_write(3, 5, 4'b1011);
        do_cbr(1'b0);
        chk(test_mode == 1'b1, "R9", "re-enter test", test_mode, 1);
        mdl_tm = 1'b1;
        chk(exp_test(3, 4) == 4'h0, "R11", "model mismatch pair", exp_test(3, 4), 0);
        do_read(3, 4, "R11");
        do_cbr(1'b1);
        exp_rf = exp_rf + 1'b1;
        chk(test_mode == 1'b0, "R12", "cbr exits test", test_mode, 0);
        mdl_tm = 1'b0;

        // random normal traffic
        for (int i = 0; i < 300; i++) begin
            int r, c;
            logic [3:0] d;
            r = int'($urandom % 8);
            c = int'($urandom % 8);
            d = 4'($urandom);
            if ($urandom % 2 == 0) do_write(r, c, d);
            else                   do_read(r, c, "R2");
        end
        chk(rfsh_row == exp_rf, "R6", "count after traffic", rfsh_row, exp_rf);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule